// File: doc/BRIEF.md
# Wiper and Initial-Value Register Controller

This block keeps the digital state of one digitally controlled resistor divider. It holds an 8-bit volatile wiper code and an 8-bit nonvolatile initial value. Both registers sit behind a single bus address. A volatile steering byte at a second address decides two things: which of the two registers a read of the shared address returns, and whether a write to it reaches the wiper alone or both registers. The wiper code drives an 8-bit output. Code 00h selects the tap nearest the low terminal, FFh the tap nearest the high terminal, and the tap position rises monotonically with the code.

A serial slave front end drives the host side through a byte-wide request channel with valid/ready handshaking. A request is taken on a rising clock edge where both `req_valid` and `req_ready` are high. The requester must hold its request fields steady while `req_valid` is high and `req_ready` is low. `req_ready` stays low in two cases: before the power-up copy has finished, and while the modelled nonvolatile store is busy. A read returns its byte on a one-cycle response pulse. That pulse cannot be stalled.

After reset the wiper holds a preset of 80h. When the supply-ready input is first seen high, the block copies the stored initial value into the wiper and raises its done flag. Any write that updates the nonvolatile register opens a busy window of a set number of cycles.

Top module: `wiper_ctrl`

## Requirements
- R1: After reset the wiper output is 80h, the steering byte is 00h, the initial-value register holds the parameter `IV_FACTORY` (default 80h), `init_done` is 0 and `req_ready` is 0.
- R2: On the first rising edge where `supply_ok` is high after reset, the wiper takes the initial-value register and `init_done` rises on that same edge. `init_done` then stays high until the next reset, and no request is accepted while it is low.
- R3: With steering byte 00h, a read of address 0 returns the initial-value register, and a write to address 0 stores the byte in both the wiper and the initial-value register.
- R4: With steering byte 80h, a read of address 0 returns the wiper, and a write to address 0 changes only the wiper. `wiper_code` always shows the wiper register.
- R5: The initial-value register never changes unless the wiper takes the same value in the same cycle.
- R6: A write to address 2 of 00h or 80h sets the steering byte. Any other value is ignored. A read of address 2 returns the steering byte.
- R7: Writes to addresses 1 and 3 change no state, and reads of them return 00h.
- R8: A write that reaches the initial-value register holds `nv_busy` high and `req_ready` low for exactly `BUSY_CYCLES` cycles after the accepting edge. The initial-value register keeps the written value through the window and afterwards.
- R9: `rsp_valid` is high for exactly the one cycle after an accepted read, with `rsp_rdata` holding the value from before that edge. It stays low after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply ready; starts the copy of the stored value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 8 | Read data |
| wiper_code | output | 8 | Current wiper tap code |
| nv_busy | output | 1 | Nonvolatile write in progress |
| init_done | output | 1 | Power-up copy finished |

## Verification
The assertions check several rules on every cycle. The steering byte only ever holds one of its two legal codes. The stored value never changes without the wiper matching it. Nothing is accepted before the copy or during a busy window. Every response pulse follows an accepted read. The bench scenarios are the only way to show the data-dependent results: what each read returns under each steering setting, that illegal steering values and reserved addresses have no effect, that the copy delivers a non-preset stored value, and that the busy window lasts exactly the set length. Random traffic checked against a bench model covers the mixed orderings.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam logic [DW-1:0] CTRL_BOTH    = 8'h00;
  localparam logic [DW-1:0] CTRL_VOL     = 8'h80;
  localparam logic [DW-1:0] WIPER_PRESET = 8'h80;
  localparam logic [DW-1:0] RSVD_READ    = 8'h00;

  typedef enum logic [1:0] {SEL_CODE, SEL_CTRL, SEL_RSVD} sel_e;

  function automatic sel_e decode_addr(input logic [AW-1:0] a);
    case (a)
      2'd0:    return SEL_CODE;
      2'd2:    return SEL_CTRL;
      default: return SEL_RSVD;
    endcase
  endfunction

  function automatic logic ctrl_legal(input logic [DW-1:0] v);
    return (v == CTRL_BOTH) || (v == CTRL_VOL);
  endfunction
endpackage

// File: rtl/wiper_powerup.sv
module wiper_powerup (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic load_iv,
  output logic init_done
);
  always_comb load_iv = supply_ok && !init_done;

  always_ff @(posedge clk) begin
    if (!rst_n)       init_done <= 1'b0;
    else if (load_iv) init_done <= 1'b1;
  end

  // R2: once the copy is finished it stays finished
  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R2: the copy pulse happens only once
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_iv |=> !load_iv);
endmodule

// File: rtl/wiper_nvstore.sv
module wiper_nvstore import wiper_pkg::*; #(
  parameter int              BUSY_CYCLES = 20,
  parameter logic [DW-1:0]   IV_FACTORY  = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nv_we,
  input  logic [DW-1:0] nv_wdata,
  output logic [DW-1:0] iv_q,
  output logic          busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iv_q  <= IV_FACTORY;
      cnt_q <= '0;
    end else if (nv_we) begin
      iv_q  <= nv_wdata;
      cnt_q <= CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb busy = (cnt_q != '0);

  // R8: no new store request while a store is in progress
  a_r8_no_we_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |-> !busy);
  // R8: the stored value is held for the whole busy window
  a_r8_iv_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(iv_q));
  // R8: every store opens a busy window
  a_r8_busy_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |=> busy);
endmodule

// File: rtl/wiper_regfile.sv
module wiper_regfile import wiper_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] iv_q,
  input  logic          load_iv,
  output logic [DW-1:0] wiper_q,
  output logic          nv_we,
  output logic [DW-1:0] nv_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] rd_mux;
  sel_e          sel;
  logic          wr_code, wr_ctrl;

  always_comb begin
    sel      = decode_addr(addr);
    wr_code  = acc && wr && (sel == SEL_CODE);
    wr_ctrl  = acc && wr && (sel == SEL_CTRL) && ctrl_legal(wdata);
    nv_we    = wr_code && (ctrl_q == CTRL_BOTH);
    nv_wdata = wdata;
    case (sel)
      SEL_CODE: rd_mux = (ctrl_q == CTRL_VOL) ? wiper_q : iv_q;
      SEL_CTRL: rd_mux = ctrl_q;
      default:  rd_mux = RSVD_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wiper_q   <= WIPER_PRESET;
      ctrl_q    <= CTRL_BOTH;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc && !wr;
      if (acc && !wr) rsp_rdata <= rd_mux;
      if (load_iv)      wiper_q <= iv_q;
      else if (wr_code) wiper_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata;
    end
  end

  // R6: the steering byte only ever holds a legal code
  a_r6_ctrl_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_legal(ctrl_q));
  // R5: a store to the initial value also lands in the wiper
  a_r5_store_hits_wiper: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |=> (wiper_q == $past(nv_wdata)));
  // R9: a response only follows an accepted read
  a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc && !wr));
  // R2: the copy never collides with a host access
  a_r2_load_no_acc: assert property (@(posedge clk) disable iff (!rst_n)
    load_iv |-> !acc);
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl import wiper_pkg::*; #(
  parameter int            BUSY_CYCLES = 20,
  parameter logic [7:0]    IV_FACTORY  = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [1:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic [7:0] wiper_code,
  output logic       nv_busy,
  output logic       init_done
);
  logic          load_iv;
  logic          acc;
  logic          nv_we;
  logic [DW-1:0] nv_wdata;
  logic [DW-1:0] iv_q;

  wiper_powerup u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .load_iv   (load_iv),
    .init_done (init_done)
  );

  wiper_nvstore #(.BUSY_CYCLES(BUSY_CYCLES), .IV_FACTORY(IV_FACTORY)) u_nv (
    .clk      (clk),
    .rst_n    (rst_n),
    .nv_we    (nv_we),
    .nv_wdata (nv_wdata),
    .iv_q     (iv_q),
    .busy     (nv_busy)
  );

  always_comb begin
    req_ready = init_done && !nv_busy;
    acc       = req_valid && req_ready;
  end

  wiper_regfile u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .wr        (req_write),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .iv_q      (iv_q),
    .load_iv   (load_iv),
    .wiper_q   (wiper_code),
    .nv_we     (nv_we),
    .nv_wdata  (nv_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R5: any change of the stored value is matched by the wiper
  a_r5_iv_implies_wiper: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_q != $past(iv_q)) |-> (wiper_code == iv_q));
  // R2: nothing is accepted before the power-up copy
  a_r2_no_ready_early: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);
  // R8: busy blocks the request channel
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |-> !req_ready);
endmodule

// File: tb/wiper_ctrl_tb.sv
module wiper_ctrl_tb;
  localparam int         BUSY = 5;
  localparam logic [7:0] IVF  = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0, supply_ok = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, nv_busy, init_done;
  logic [7:0] rsp_rdata, wiper_code;

  int checks = 0, fails = 0;
  logic [7:0] m_wiper, m_iv, m_ctrl;

  always #4 clk = ~clk;

  wiper_ctrl #(.BUSY_CYCLES(BUSY), .IV_FACTORY(IVF)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wiper_code(wiper_code), .nv_busy(nv_busy), .init_done(init_done));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    if (a == 2'd0) return (m_ctrl == 8'h80) ? m_wiper : m_iv;
    if (a == 2'd2) return m_ctrl;
    return 8'h00;
  endfunction

  // one request; returns at the negedge after the accepting edge
  task automatic do_req(input bit w, input logic [1:0] a, input logic [7:0] d,
                        input string req);
    logic [7:0] expv;
    bit nvw;
    int lowcnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    expv = exp_read(a);
    nvw  = w && (a == 2'd0) && (m_ctrl == 8'h00);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (w) begin
      if (a == 2'd0) begin
        m_wiper = d;
        if (m_ctrl == 8'h00) m_iv = d;
      end else if (a == 2'd2 && (d == 8'h00 || d == 8'h80)) begin
        m_ctrl = d;
      end
      chk(!rsp_valid, "R9", "rsp after write", rsp_valid, 0);
      chk(wiper_code == m_wiper, req, "wiper after write", wiper_code, m_wiper);
    end else begin
      chk(rsp_valid, "R9", "rsp_valid after read", rsp_valid, 1);
      chk(rsp_rdata == expv, req, "read data", rsp_rdata, expv);
      @(negedge clk);
      chk(!rsp_valid, "R9", "rsp one cycle", rsp_valid, 0);
    end
    if (nvw) begin
      lowcnt = 0;
      while (!req_ready && lowcnt < 100) begin
        lowcnt++;
        @(negedge clk);
      end
      chk(lowcnt == BUSY, "R8", "busy window length", lowcnt, BUSY);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_wiper = 8'h80; m_iv = IVF; m_ctrl = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(wiper_code == 8'h80, "R1", "wiper preset", wiper_code, 8'h80);
    chk(!init_done, "R1", "init_done", init_done, 0);
    chk(!req_ready, "R1", "req_ready", req_ready, 0);
    chk(!nv_busy, "R1", "nv_busy", nv_busy, 0);
    // R2: valid held but not accepted before copy
    req_valid = 1'b1; req_write = 1'b1; req_addr = 2'd0; req_wdata = 8'hEE;
    @(negedge clk);
    chk(wiper_code == 8'h80, "R2", "no accept before copy", wiper_code, 8'h80);
    req_valid = 1'b0;
    supply_ok = 1'b1;
    @(negedge clk);
    chk(wiper_code == IVF, "R2", "copy of stored value", wiper_code, IVF);
    chk(init_done, "R2", "init_done rises", init_done, 1);
    m_wiper = IVF;
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk(init_done, "R2", "init_done sticky", init_done, 1);
    chk(wiper_code == IVF, "R2", "wiper unchanged", wiper_code, IVF);
    // R1/R6: steering reads 00h
    do_req(1'b0, 2'd2, 8'h00, "R1");
    // R3: steering 00h
    do_req(1'b0, 2'd0, 8'h00, "R3");
    do_req(1'b1, 2'd0, 8'h3C, "R3");
    do_req(1'b0, 2'd0, 8'h00, "R3");
    // R6: illegal steering ignored
    do_req(1'b1, 2'd2, 8'h81, "R6");
    do_req(1'b0, 2'd2, 8'h00, "R6");
    do_req(1'b1, 2'd2, 8'h80, "R6");
    do_req(1'b0, 2'd2, 8'h00, "R6");
    // R4: steering 80h, wiper only; extreme codes
    do_req(1'b1, 2'd0, 8'hFF, "R4");
    do_req(1'b0, 2'd0, 8'h00, "R4");
    do_req(1'b1, 2'd0, 8'h00, "R4");
    do_req(1'b1, 2'd2, 8'h00, "R4");
    do_req(1'b0, 2'd0, 8'h00, "R4");   // stored value still 3Ch
    // R7: reserved addresses
    do_req(1'b1, 2'd1, 8'hA5, "R7");
    do_req(1'b1, 2'd3, 8'h80, "R7");
    do_req(1'b0, 2'd1, 8'h00, "R7");
    do_req(1'b0, 2'd3, 8'h00, "R7");
    do_req(1'b0, 2'd2, 8'h00, "R7");
    do_req(1'b0, 2'd0, 8'h00, "R7");
    // R5/R8: mixed random traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      bit w;
      a = 2'($urandom_range(0, 3));
      w = 1'($urandom_range(0, 1));
      d = 8'($urandom);
      if (a == 2'd2 && $urandom_range(0, 3) != 0) d = ($urandom_range(0, 1) != 0) ? 8'h80 : 8'h00;
      do_req(w, a, d, "R5");
    end
    // final: stored value visible through steering 00h
    do_req(1'b1, 2'd2, 8'h00, "R8");
    do_req(1'b0, 2'd0, 8'h00, "R8");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule